// File: doc/BRIEF.md
# Register-Machine Execution Unit with Literal Operand Forms

This block is the arithmetic and logic stage of a small load/store register machine. Each cycle it takes a 6-bit operation code, two 32-bit register values and the 16-bit constant field of the instruction. It produces the 32-bit value to be written to the destination register. Codes in the `0x2_` group draw their second operand from the second register. Codes in the `0x3_` group use the constant field, sign-extended to 32 bits, in its place. The low four code bits select the operation, and they mean the same thing in both groups.

The unit covers wrapping add and subtract, the low word of a multiply, three signed or equality comparisons that yield exactly 0 or 1, three bitwise operations, and left, logical-right and arithmetic-right shifts. Division and every code outside the supported set give a zero result and raise an illegal-operation flag. The result and the flag are captured in one register stage, so a decoder or register file can feed operands in one cycle and take the write-back value in the next.

Top module: `alu_exec`

## Requirements
- R1: Code bit 4 selects the second operand. When it is 0 the `rb_val` port is used and `lit` has no effect. When it is 1, `lit` sign-extended from bit 15 to 32 bits is used and `rb_val` has no effect.
- R2: Add (func 0x0) and subtract (func 0x1) compute `ra + op2` and `ra - op2` modulo 2^32, with no trap or flag on overflow.
- R3: Multiply (func 0x2) returns the low 32 bits of the product of the two operands.
- R4: The comparisons return 1 when the relation holds and 0 otherwise, with bits 31:1 always zero. Func 0x4 tests equality, func 0x5 tests signed less-than and func 0x6 tests signed less-or-equal.
- R5: Func 0x8, 0x9 and 0xA give bitwise AND, OR and XOR. In the literal group they use the sign-extended constant, never a zero-extended one.
- R6: For shifts, the distance is bits 4:0 of the second operand. Higher bits of that operand are ignored.
- R7: Left shift (func 0xC) and logical right shift (func 0xD) fill the vacated bits with zeros. Arithmetic right shift (func 0xE) fills them with copies of bit 31 of the first operand. A distance of 0 returns the first operand unchanged.
- R8: The legal codes are 0x20, 0x21, 0x22, 0x24, 0x25, 0x26, 0x28, 0x29, 0x2A, 0x2C, 0x2D and 0x2E, and the same codes plus 0x10. Every other code, including division 0x23 and 0x33, gives a result of 0 with `illegal` set to 1. Legal codes give `illegal` = 0.
- R9: `result` and `illegal` update on the rising clock edge after the inputs are presented, which is one cycle of latency. While `rst_n` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Operation code |
| ra_val | input | 32 | First register operand |
| rb_val | input | 32 | Second register operand (register group) |
| lit | input | 16 | Signed constant field (literal group) |
| result | output | 32 | Registered result for the destination register |
| illegal | output | 1 | Registered flag for an unsupported operation code |

## Verification
Every result and illegal flag is due exactly one rising edge after its operands are applied. There are no multi-cycle operations, so the latency is the same for every code. The bench changes inputs on a falling edge and reads the outputs on the next falling edge, half a period after the capturing edge. Each check therefore sees the result of exactly one stimulus. Back-to-back vectors in the hand-written table and in the sweep over all legal codes confirm that no earlier operand leaks into a later result.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int FUNC_W = 4;

    localparam logic [FUNC_W-1:0] FN_ADD = 4'h0;
    localparam logic [FUNC_W-1:0] FN_SUB = 4'h1;
    localparam logic [FUNC_W-1:0] FN_MUL = 4'h2;
    localparam logic [FUNC_W-1:0] FN_EQ  = 4'h4;
    localparam logic [FUNC_W-1:0] FN_LT  = 4'h5;
    localparam logic [FUNC_W-1:0] FN_LE  = 4'h6;
    localparam logic [FUNC_W-1:0] FN_AND = 4'h8;
    localparam logic [FUNC_W-1:0] FN_OR  = 4'h9;
    localparam logic [FUNC_W-1:0] FN_XOR = 4'hA;
    localparam logic [FUNC_W-1:0] FN_SHL = 4'hC;
    localparam logic [FUNC_W-1:0] FN_SHR = 4'hD;
    localparam logic [FUNC_W-1:0] FN_SRA = 4'hE;

    typedef struct packed {
        logic [FUNC_W-1:0] func;
        logic              use_lit;
        logic              legal;
        logic              is_cmp;
        logic              is_shift;
    } ctrl_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
#(
    parameter int OP_W = 6
) (
    input  logic [OP_W-1:0] opcode,
    output ctrl_t           ctrl
);
    localparam int GRP_BIT = OP_W - 1;
    localparam int LIT_BIT = OP_W - 2;

    logic func_ok;

    always_comb begin
        ctrl.func     = opcode[FUNC_W-1:0];
        ctrl.use_lit  = opcode[LIT_BIT];
        ctrl.is_cmp   = (ctrl.func == FN_EQ) || (ctrl.func == FN_LT) || (ctrl.func == FN_LE);
        ctrl.is_shift = (ctrl.func == FN_SHL) || (ctrl.func == FN_SHR) || (ctrl.func == FN_SRA);
        unique case (ctrl.func)
            FN_ADD, FN_SUB, FN_MUL,
            FN_EQ,  FN_LT,  FN_LE,
            FN_AND, FN_OR,  FN_XOR,
            FN_SHL, FN_SHR, FN_SRA: func_ok = 1'b1;
            default:                func_ok = 1'b0;
        endcase
        ctrl.legal = opcode[GRP_BIT] && func_ok;
    end
endmodule

// File: rtl/alu_operand.sv
module alu_operand #(
    parameter int DATA_W = 32,
    parameter int LIT_W  = 16
) (
    input  logic              use_lit,
    input  logic [DATA_W-1:0] rb_val,
    input  logic [LIT_W-1:0]  lit,
    output logic [DATA_W-1:0] op2
);
    localparam int EXT_W = DATA_W - LIT_W;

    logic [DATA_W-1:0] lit_ext;

    generate
        if (EXT_W > 0) begin : g_ext
            assign lit_ext = {{EXT_W{lit[LIT_W-1]}}, lit};
        end else begin : g_trunc
            assign lit_ext = lit[DATA_W-1:0];
        end
    endgenerate

    assign op2 = use_lit ? lit_ext : rb_val;
endmodule

// File: rtl/alu_arith.sv
module alu_arith
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [FUNC_W-1:0] func,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    logic [DATA_W-1:0] sum, diff, prod;
    logic              eq, lt;

    always_comb begin
        sum  = a + b;
        diff = a - b;
        prod = a * b;
        eq   = (a == b);
        lt   = ($signed(a) < $signed(b));
        unique case (func)
            FN_ADD:  y = sum;
            FN_SUB:  y = diff;
            FN_MUL:  y = prod;
            FN_EQ:   y = {{(DATA_W-1){1'b0}}, eq};
            FN_LT:   y = {{(DATA_W-1){1'b0}}, lt};
            FN_LE:   y = {{(DATA_W-1){1'b0}}, lt | eq};
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu_bitshift.sv
module alu_bitshift
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [FUNC_W-1:0] func,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0]          amt;
    logic signed [DATA_W-1:0] a_s;

    always_comb begin
        amt = b[SH_W-1:0];
        a_s = $signed(a);
        unique case (func)
            FN_AND:  y = a & b;
            FN_OR:   y = a | b;
            FN_XOR:  y = a ^ b;
            FN_SHL:  y = a << amt;
            FN_SHR:  y = a >> amt;
            FN_SRA:  y = a_s >>> amt;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/alu_exec.sv
module alu_exec
    import alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LIT_W  = 16,
    parameter int OP_W   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   opcode,
    input  logic [DATA_W-1:0] ra_val,
    input  logic [DATA_W-1:0] rb_val,
    input  logic [LIT_W-1:0]  lit,
    output logic [DATA_W-1:0] result,
    output logic              illegal
);
    localparam int SH_W = $clog2(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              illegal;
    } out_t;

    ctrl_t             ctrl;
    logic [DATA_W-1:0] op2;
    logic [DATA_W-1:0] arith_y;
    logic [DATA_W-1:0] bits_y;
    out_t              out_d, out_q;

    alu_decode #(.OP_W(OP_W)) u_decode (
        .opcode (opcode),
        .ctrl   (ctrl)
    );

    alu_operand #(.DATA_W(DATA_W), .LIT_W(LIT_W)) u_operand (
        .use_lit (ctrl.use_lit),
        .rb_val  (rb_val),
        .lit     (lit),
        .op2     (op2)
    );

    alu_arith #(.DATA_W(DATA_W)) u_arith (
        .func (ctrl.func),
        .a    (ra_val),
        .b    (op2),
        .y    (arith_y)
    );

    alu_bitshift #(.DATA_W(DATA_W)) u_bitshift (
        .func (ctrl.func),
        .a    (ra_val),
        .b    (op2),
        .y    (bits_y)
    );

    // Func bit 3 splits the arithmetic/compare half from the logic/shift half.
    always_comb begin
        out_d.illegal = !ctrl.legal;
        if (!ctrl.legal)
            out_d.result = '0;
        else if (ctrl.func[FUNC_W-1])
            out_d.result = bits_y;
        else
            out_d.result = arith_y;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    assign result  = out_q.result;
    assign illegal = out_q.illegal;

    // R4: a comparison leaves only bit 0 free
    assert_cmp_bool_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.legal && ctrl.is_cmp) |=> (result[DATA_W-1:1] == '0));

    // R8: unsupported codes give a flagged zero
    assert_illegal_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.legal |=> (illegal && result == '0));

    // R8: supported codes never raise the flag
    assert_legal_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.legal |=> !illegal);

    // R2: the difference plus the subtrahend restores the first operand
    assert_sub_inverse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.legal && ctrl.func == FN_SUB) |=> (result + $past(op2) == $past(ra_val)));

    // R7: a zero shift distance passes the first operand through
    assert_shift_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.legal && ctrl.is_shift && op2[SH_W-1:0] == '0) |=> (result == $past(ra_val)));
endmodule

// File: tb/alu_exec_bench.sv
module alu_exec_bench;

    typedef struct packed {
        logic [5:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [15:0] lit;
        logic [31:0] exp;
        logic        ill;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 40;
    localparam vec_t VEC [NVEC] = '{
        '{6'h20, 32'h5,        32'h7,        16'h0,    32'hC,        1'b0, 4'd2}, // R2
        '{6'h20, 32'hFFFFFFFF, 32'h1,        16'h0,    32'h0,        1'b0, 4'd2}, // R2 wrap
        '{6'h21, 32'h0,        32'h1,        16'h0,    32'hFFFFFFFF, 1'b0, 4'd2}, // R2 wrap
        '{6'h22, 32'h10000,    32'h10000,    16'h0,    32'h0,        1'b0, 4'd3}, // R3
        '{6'h22, 32'h3,        32'hFFFFFFFF, 16'h0,    32'hFFFFFFFD, 1'b0, 4'd3}, // R3
        '{6'h24, 32'h9,        32'h9,        16'h0,    32'h1,        1'b0, 4'd4}, // R4
        '{6'h24, 32'h9,        32'h8,        16'h0,    32'h0,        1'b0, 4'd4}, // R4
        '{6'h25, 32'hFFFFFFFF, 32'h1,        16'h0,    32'h1,        1'b0, 4'd4}, // R4 signed
        '{6'h25, 32'h5,        32'h5,        16'h0,    32'h0,        1'b0, 4'd4}, // R4
        '{6'h26, 32'h5,        32'h5,        16'h0,    32'h1,        1'b0, 4'd4}, // R4
        '{6'h26, 32'h1,        32'h80000000, 16'h0,    32'h0,        1'b0, 4'd4}, // R4 signed
        '{6'h28, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0,    32'hF000F000, 1'b0, 4'd5}, // R5
        '{6'h29, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0,    32'hFFF0FFF0, 1'b0, 4'd5}, // R5
        '{6'h2A, 32'hF0F0F0F0, 32'hFF00FF00, 16'h0,    32'h0FF00FF0, 1'b0, 4'd5}, // R5
        '{6'h2C, 32'h1,        32'd31,       16'h0,    32'h80000000, 1'b0, 4'd7}, // R7
        '{6'h2C, 32'h1,        32'd35,       16'h0,    32'h8,        1'b0, 4'd6}, // R6
        '{6'h2D, 32'h80000000, 32'd31,       16'h0,    32'h1,        1'b0, 4'd7}, // R7
        '{6'h2E, 32'h80000000, 32'd31,       16'h0,    32'hFFFFFFFF, 1'b0, 4'd7}, // R7
        '{6'h2E, 32'h80000000, 32'd0,        16'h0,    32'h80000000, 1'b0, 4'd7}, // R7
        '{6'h2D, 32'hF0000000, 32'hFFFFFFE0, 16'h0,    32'hF0000000, 1'b0, 4'd6}, // R6
        '{6'h30, 32'd10,       32'h0,        16'h8000, 32'hFFFF800A, 1'b0, 4'd1}, // R1
        '{6'h31, 32'h0,        32'h0,        16'h0001, 32'hFFFFFFFF, 1'b0, 4'd2}, // R2
        '{6'h32, 32'd7,        32'h0,        16'hFFFE, 32'hFFFFFFF2, 1'b0, 4'd3}, // R3
        '{6'h34, 32'hFFFFFFFF, 32'h0,        16'hFFFF, 32'h1,        1'b0, 4'd4}, // R4
        '{6'h35, 32'hFFFF7FFF, 32'h0,        16'h8000, 32'h1,        1'b0, 4'd4}, // R4
        '{6'h36, 32'h1,        32'h0,        16'h0000, 32'h0,        1'b0, 4'd4}, // R4
        '{6'h38, 32'h12345678, 32'h0,        16'hFFFF, 32'h12345678, 1'b0, 4'd5}, // R5
        '{6'h39, 32'h0,        32'h0,        16'h8000, 32'hFFFF8000, 1'b0, 4'd5}, // R5
        '{6'h3A, 32'hFFFFFFFF, 32'h0,        16'h00FF, 32'hFFFFFF00, 1'b0, 4'd5}, // R5
        '{6'h3C, 32'h1,        32'h0,        16'h001F, 32'h80000000, 1'b0, 4'd7}, // R7
        '{6'h3C, 32'h1,        32'h0,        16'hFFE1, 32'h2,        1'b0, 4'd6}, // R6
        '{6'h3D, 32'hF0000000, 32'h0,        16'h0004, 32'h0F000000, 1'b0, 4'd7}, // R7
        '{6'h3E, 32'hF0000000, 32'h0,        16'h0004, 32'hFF000000, 1'b0, 4'd7}, // R7
        '{6'h20, 32'h1,        32'h2,        16'hFFFF, 32'h3,        1'b0, 4'd1}, // R1 lit ignored
        '{6'h30, 32'h1,        32'h100,      16'h0002, 32'h3,        1'b0, 4'd1}, // R1 rb ignored
        '{6'h23, 32'h8,        32'h2,        16'h0,    32'h0,        1'b1, 4'd8}, // R8 div
        '{6'h33, 32'h8,        32'h0,        16'h0002, 32'h0,        1'b1, 4'd8}, // R8 div
        '{6'h00, 32'h8,        32'h2,        16'h0,    32'h0,        1'b1, 4'd8}, // R8
        '{6'h27, 32'h8,        32'h2,        16'h0,    32'h0,        1'b1, 4'd8}, // R8
        '{6'h3F, 32'h8,        32'h2,        16'h0,    32'h0,        1'b1, 4'd8}  // R8
    };

    localparam logic [5:0] OPS [24] = '{
        6'h20, 6'h21, 6'h22, 6'h24, 6'h25, 6'h26, 6'h28, 6'h29, 6'h2A, 6'h2C, 6'h2D, 6'h2E,
        6'h30, 6'h31, 6'h32, 6'h34, 6'h35, 6'h36, 6'h38, 6'h39, 6'h3A, 6'h3C, 6'h3D, 6'h3E
    };
    localparam logic [31:0] PA [4] = '{32'h7FFFFFFF, 32'h80000000, 32'hDEADBEEF, 32'h00000000};
    localparam logic [31:0] PB [4] = '{32'h00000001, 32'h0000001F, 32'hFFFFFFFF, 32'h00000000};
    localparam logic [15:0] PL [4] = '{16'h8000, 16'h7FFF, 16'h001F, 16'h0000};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  opcode = '0;
    logic [31:0] ra_val = '0;
    logic [31:0] rb_val = '0;
    logic [15:0] lit = '0;
    logic [31:0] result;
    logic        illegal;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    alu_exec u_alu_exec (
        .clk     (clk),
        .rst_n   (rst_n),
        .opcode  (opcode),
        .ra_val  (ra_val),
        .rb_val  (rb_val),
        .lit     (lit),
        .result  (result),
        .illegal (illegal)
    );

    // Reference model written from the requirements.
    function automatic logic [32:0] ref_model(input logic [5:0] op, input logic [31:0] a,
                                              input logic [31:0] rb, input logic [15:0] l);
        logic [31:0] b;
        logic [31:0] y;
        logic [4:0]  sh;
        b  = op[4] ? {{16{l[15]}}, l} : rb;
        sh = b[4:0];
        y  = '0;
        if (op[5:4] == 2'b00 || op[5:4] == 2'b01) return {32'h0, 1'b1};
        case (op[3:0])
            4'h0: y = a + b;
            4'h1: y = a - b;
            4'h2: y = a * b;
            4'h4: y = (a == b) ? 32'd1 : 32'd0;
            4'h5: y = ($signed(a) <  $signed(b)) ? 32'd1 : 32'd0;
            4'h6: y = ($signed(a) <= $signed(b)) ? 32'd1 : 32'd0;
            4'h8: y = a & b;
            4'h9: y = a | b;
            4'hA: y = a ^ b;
            4'hC: y = a << sh;
            4'hD: y = a >> sh;
            4'hE: begin
                y = a >> sh;
                for (int i = 0; i < 32; i++) if (i >= 32 - sh && sh != 0) y[i] = a[31];
            end
            default: return {32'h0, 1'b1};
        endcase
        return {y, 1'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp,
                         input logic gill, input logic eill);
        n_run++;
        if (got !== exp || gill !== eill) begin
            n_fail++;
            $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
                     req, got, gill, exp, eill);
        end
    endtask

    // Inputs change on a falling edge; the rising edge captures; read on the next falling edge.
    task automatic apply(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] l);
        @(negedge clk);
        opcode = op; ra_val = a; rb_val = b; lit = l;
        @(negedge clk);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: result=%h illegal=%b expected completion", result, illegal);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [32:0] r;
        // R9: outputs held at zero in reset even with live inputs
        opcode = 6'h29; ra_val = 32'hFFFFFFFF; rb_val = 32'h1; lit = 16'h0;
        repeat (3) @(negedge clk);
        check("R9 reset", result, 32'h0, illegal, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: one-cycle latency, back-to-back values
        @(negedge clk);
        opcode = 6'h20; ra_val = 32'd100; rb_val = 32'd1;
        @(posedge clk);
        #1;
        opcode = 6'h21; ra_val = 32'd100; rb_val = 32'd1;
        @(negedge clk);
        check("R9 latency first", result, 32'd101, illegal, 1'b0);
        @(negedge clk);
        check("R9 latency second", result, 32'd99, illegal, 1'b0);

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i].op, VEC[i].a, VEC[i].b, VEC[i].lit);
            check($sformatf("R%0d vec%0d op=%h", VEC[i].req, i, VEC[i].op),
                  result, VEC[i].exp, illegal, VEC[i].ill);
        end

        // Sweep every legal code against the reference model (R1 R2 R3 R4 R5 R6 R7 R8)
        for (int k = 0; k < 24; k++) begin
            for (int p = 0; p < 4; p++) begin
                r = ref_model(OPS[k], PA[p], PB[p], PL[p]);
                apply(OPS[k], PA[p], PB[p], PL[p]);
                check($sformatf("R8 sweep op=%h pat%0d", OPS[k], p), result, r[32:1], illegal, r[0]);
            end
        end

        // R9: reset asserted mid-run clears the outputs
        apply(6'h29, 32'h5, 32'hA, 16'h0);
        check("R5 pre-reset", result, 32'hF, illegal, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9 async reset", result, 32'h0, illegal, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule